// File: doc/BRIEF.md
# Rounding Arithmetic Right Shifter

This execution unit sits in a 64-bit datapath. It takes a 64-bit source operand and a 5-bit unsigned shift amount. Only the low 32-bit word of the source is used. That word is shifted right arithmetically and rounded to nearest: the most significant bit that falls off the right edge is added back into the kept part. A 33-bit intermediate holds the sum so that it cannot overflow. The 32-bit result is then sign-extended to 64 bits. A shift amount of zero skips the rounding and passes the low word through unchanged.

The datapath is purely combinational and feeds one output register. The register loads whenever `in_valid` is high. A two-state machine tracks whether the register holds a result issued in the previous cycle, and drives `out_valid` from that:
- `ST_EMPTY` is the reset state and means no result is present.
- `ST_FULL` means a result was captured on the last edge.
- The transition `take` (`ST_EMPTY` → `ST_FULL`) fires when `in_valid` is high.
- The transition `refill` (`ST_FULL` → `ST_FULL`) fires when `in_valid` is high again.
- The transition `drain` (`ST_FULL` → `ST_EMPTY`) fires when `in_valid` is low.
- The transition `idle` (`ST_EMPTY` → `ST_EMPTY`) fires when `in_valid` is low.

Top module: `rsh_round_unit`

## Requirements
- R1: Bits [63:32] of `src` have no effect on `out_result`. Only `src[31:0]` takes part.
- R2: The shift is arithmetic: vacated high positions take `src[31]`. A non-negative low word never yields a negative result.
- R3: For a shift amount s in 1..31, the result is the 33-bit sign-extension of `src[31:s-1]`, plus one, with its lowest bit dropped. Example: 0x7FFFFFFF with s=1 gives 0x40000000, and no overflow occurs.
- R4: For a shift amount of 0, the 32-bit result equals `src[31:0]` with no rounding.
- R5: `out_result[63:32]` always equals copies of `out_result[31]`.
- R6: When `in_valid` is high at a rising edge, the result for that cycle's inputs appears on `out_result` with `out_valid`=1 after that edge. When `in_valid` is low at an edge, `out_valid` is 0 after it and `out_result` keeps its value.
- R7: A synchronous active-high `rst` makes `out_valid`=0 and `out_result`=0 after the edge, whatever `in_valid` is.
- R8: A negative value exactly halfway between two results rounds toward positive infinity. Examples: -3 with s=1 gives -1, and -1 with s=1 gives 0. With s=31, 0x80000000 gives -1 and 0xC0000000 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load the output register with this cycle's result |
| src | input | 64 | Source operand; only bits [31:0] are used |
| shamt | input | 5 | Unsigned shift amount, 0 to 31 |
| out_valid | output | 1 | High for the cycle after a load |
| out_result | output | 64 | Rounded, shifted, sign-extended result |

## Verification
Every result is due one rising edge after the cycle in which its inputs are presented with `in_valid` high. The same edge sets or clears `out_valid`. The bench drives inputs on the falling edge, updates its behavioural model at that point, and compares the model's expected register contents with the outputs at the next falling edge, so each comparison lands one full register stage after its stimulus. Idle cycles and a reset taken while `in_valid` is high are compared the same way. A few hand-worked corner values are also checked against literal constants, independently of the model.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
    localparam int XLEN = 64;
    localparam int WLEN = 32;
    localparam int SHW  = $clog2(WLEN);

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/rsh_word_pick.sv
module rsh_word_pick #(
    parameter int XW = 64,
    parameter int WW = 32
) (
    input  logic [XW-1:0] src,
    output logic [WW-1:0] word
);
    // Only the low word feeds the shifter; upper bits are dropped here.
    assign word = src[WW-1:0];
endmodule

// File: rtl/rsh_round_core.sv
module rsh_round_core #(
    parameter int WW = 32,
    parameter int SW = $clog2(WW)
) (
    input  logic [WW-1:0] word,
    input  logic [SW-1:0] amt,
    output logic [WW-1:0] res
);
    logic signed [WW:0] ext;
    logic signed [WW:0] kept;
    logic        [WW:0] sum;
    logic        [SW-1:0] amt_m1;

    always_comb begin
        ext    = {word[WW-1], word};
        amt_m1 = amt - SW'(1);
        // Keep bits [WW-1:amt-1]; the lowest kept bit is the rounding bit.
        kept   = ext >>> amt_m1;
        sum    = kept + {{WW{1'b0}}, 1'b1};
        if (amt == '0) begin
            res = word;
        end else begin
            res = sum[WW:1];
        end
    end
endmodule

// File: rtl/rsh_sext.sv
module rsh_sext #(
    parameter int WW = 32,
    parameter int XW = 64
) (
    input  logic [WW-1:0] narrow,
    output logic [XW-1:0] wide
);
    localparam int PAD = XW - WW;
    assign wide = {{PAD{narrow[WW-1]}}, narrow};
endmodule

// File: rtl/rsh_out_stage.sv
module rsh_out_stage
    import rsh_pkg::*;
#(
    parameter int XW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [XW-1:0] din,
    output logic          valid,
    output logic [XW-1:0] dout
);
    out_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = load ? ST_FULL : ST_EMPTY; // take / idle
            ST_FULL:  state_nx = load ? ST_FULL : ST_EMPTY; // refill / drain
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (load) dout <= din;
    end

    assign valid = (state == ST_FULL);

    assert_valid_after_load_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> valid);
    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> (!valid && $stable(dout)));
    assert_reset_clears_R7: assert property (@(posedge clk)
        rst |=> (!valid && dout == '0));
endmodule

// File: rtl/rsh_round_unit.sv
module rsh_round_unit
    import rsh_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] src,
    input  logic [SHW-1:0]  shamt,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result
);
    logic [WLEN-1:0] low_word;
    logic [WLEN-1:0] rounded;
    logic [XLEN-1:0] widened;

    rsh_word_pick #(.XW(XLEN), .WW(WLEN)) u_pick (
        .src  (src),
        .word (low_word)
    );

    rsh_round_core #(.WW(WLEN), .SW(SHW)) u_core (
        .word (low_word),
        .amt  (shamt),
        .res  (rounded)
    );

    rsh_sext #(.WW(WLEN), .XW(XLEN)) u_sext (
        .narrow (rounded),
        .wide   (widened)
    );

    rsh_out_stage #(.XW(XLEN)) u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .din   (widened),
        .valid (out_valid),
        .dout  (out_result)
    );

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        (!low_word[WLEN-1]) |-> !rounded[WLEN-1]);
    assert_negative_not_positive_R8: assert property (@(posedge clk) disable iff (rst)
        (low_word[WLEN-1] && shamt != '0) |-> (rounded[WLEN-1] || rounded == '0));
    assert_zero_shift_passthrough_R4: assert property (@(posedge clk) disable iff (rst)
        (shamt == '0) |-> (rounded == src[WLEN-1:0]));
    assert_upper_sign_copies_R5: assert property (@(posedge clk) disable iff (rst)
        (out_result[XLEN-1:WLEN] == {(XLEN-WLEN){out_result[WLEN-1]}}));
endmodule

// File: tb/test_rsh_round_unit.sv
module test_rsh_round_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] src;
    logic [4:0]  shamt;
    logic        out_valid;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    logic        exp_valid;
    logic [63:0] exp_result;
    string       exp_tag;
    bit          lit_pending;
    logic [63:0] lit_value;
    string       lit_tag;

    always #5 clk = ~clk;

    rsh_round_unit i_rsh_round_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
        .shamt(shamt), .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [63:0] ref_fn(logic [63:0] x, int sa);
        int     w;
        longint v;
        w = int'(x[31:0]);
        v = longint'(w);
        if (sa != 0) v = (v + (longint'(1) <<< (sa - 1))) >>> sa;
        return 64'(v);
    endfunction

    task automatic check_outputs();
        n_checks++;
        if (out_valid !== exp_valid || out_result !== exp_result) begin
            n_fails++;
            $display("FAIL %s: got valid=%0b result=%h, expected valid=%0b result=%h",
                     exp_tag, out_valid, out_result, exp_valid, exp_result);
        end
        if (lit_pending) begin
            n_checks++;
            if (out_result !== lit_value) begin
                n_fails++;
                $display("FAIL %s: got %h, expected %h", lit_tag, out_result, lit_value);
            end
            lit_pending = 1'b0;
        end
    endtask

    // Compare last cycle's effect, then drive this cycle and update the model.
    task automatic step(bit r, bit v, logic [63:0] x, int sa, string tag);
        @(negedge clk);
        check_outputs();
        rst = r; in_valid = v; src = x; shamt = 5'(sa);
        exp_tag = tag;
        if (r) begin
            exp_valid = 1'b0; exp_result = '0;
        end else begin
            exp_valid = v;
            if (v) exp_result = ref_fn(x, sa);
        end
    endtask

    task automatic known(logic [63:0] x, int sa, logic [63:0] e, string tag);
        step(1'b0, 1'b1, x, sa, tag);
        lit_pending = 1'b1; lit_value = e; lit_tag = tag;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    logic [31:0] corners [8];
    initial begin
        corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h8000_0000; corners[3] = 32'h7FFF_FFFF;
        corners[4] = 32'hC000_0000; corners[5] = 32'h0000_0001;
        corners[6] = 32'hFFFF_FFFD; corners[7] = 32'h5555_AAAA;

        rst = 1'b1; in_valid = 1'b0; src = '0; shamt = '0;
        exp_valid = 1'b0; exp_result = '0; exp_tag = "R7 reset";
        lit_pending = 1'b0; lit_value = '0; lit_tag = "";
        repeat (3) step(1'b1, 1'b0, 64'd0, 0, "R7 reset state");
        step(1'b0, 1'b0, 64'd0, 0, "R7 reset state");

        known(64'h0000_0000_7FFF_FFFF, 1, 64'h0000_0000_4000_0000, "R3 no overflow");
        known(64'hFFFF_FFFF_FFFF_FFFD, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R8 -3 by 1");
        known(64'h0000_0000_FFFF_FFFF, 1, 64'h0, "R8 -1 by 1");
        known(64'h0000_0000_8000_0000, 31, 64'hFFFF_FFFF_FFFF_FFFF, "R8 min by 31");
        known(64'h0000_0000_C000_0000, 31, 64'h0, "R8 C0000000 by 31");
        known(64'h0000_0000_7FFF_FFFF, 31, 64'h1, "R2 max by 31");
        known(64'hDEAD_BEEF_1234_5678, 0, 64'h0000_0000_1234_5678, "R4 zero shift");
        known(64'h1234_5678_8765_4321, 0, 64'hFFFF_FFFF_8765_4321, "R5 sign extend");
        known(64'h0000_0000_0000_0006, 2, 64'h2, "R3 round up 6 by 2");
        known(64'h0000_0000_0000_0005, 2, 64'h1, "R3 round down 5 by 2");

        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 32; s++) begin
                step(1'b0, 1'b1, {32'h0, corners[c]}, s, "R3 corner sweep");
                step(1'b0, 1'b1, {$urandom(), corners[c]}, s, "R1 upper bits ignored");
            end
        end

        step(1'b0, 1'b0, 64'hFFFF_0000_0000_1111, 7, "R6 idle holds");
        step(1'b0, 1'b0, 64'h0, 3, "R6 idle holds");
        step(1'b0, 1'b1, 64'h0000_0000_8000_0001, 4, "R6 load after idle");

        for (int k = 0; k < 400; k++) begin
            step(1'b0, ($urandom() % 4) != 0, {$urandom(), $urandom()},
                 int'($urandom() % 32), "R2 random");
        end

        step(1'b1, 1'b1, 64'h0000_0000_7654_3210, 3, "R7 reset while loading");
        step(1'b0, 1'b0, 64'h0, 0, "R7 after reset");
        step(1'b0, 1'b0, 64'h0, 0, "R6 idle");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule